// File: doc/BRIEF.md
# Rotary Encoder and Push-Button Status Registers

This block turns the debounced state of a small control panel into three 32-bit words that a processor can read at any time. The panel has five rotary encoders, each with two quadrature lines and a push button, and one standalone button. Sixteen debounced levels arrive with sixteen change flags. An update strobe marks the cycle in which both sets are valid.

For each encoder the block decodes quadrature steps and adds them to one of two wrapping 4-bit position counters. The counter that moves depends on whether the encoder's own button is held when the step completes. Software can therefore read rotation and press-and-turn gestures separately, even if it polls only a few times per second. For each button the block holds its latest level and the time since that button last changed. A separate field holds the time since any control changed. Time is counted in ticks from a free-running prescaler. At the default setting of 10,000,000 cycles, a 100 MHz clock gives 100 ms ticks.

Top module: `enc_status_regs`

## Requirements
- R1: A synchronous active-high `rst` clears every position counter, button state, duration and the idle field, so all three output words read zero.
- R2: Input lines map as follows. Encoder k (k = 0..4) uses bit 3k for quadrature line A, bit 3k+1 for line B and bit 3k+2 for its button. Bit 15 is the standalone button, and a level of 1 means pressed. Levels and change flags have an effect only in a cycle where `updStrobe` is 1.
- R3: Quadrature is read as the pair {A,B}. One full cycle 00→01→11→10→00, sampled on update strobes, adds 1 to the selected position counter. The reverse cycle 00→10→11→01→00 subtracts 1. The count happens on the strobe that returns the pair to 00.
- R4: A sample that jumps two phases at once (for example 00→11) does not move the decoder. A cycle that returns to 00 before it completes changes no counter.
- R5: A step goes to the pressed-position counter if the encoder's button level is 1 on the strobe that completes the step. Otherwise it goes to the normal-position counter.
- R6: Position counters wrap modulo 16 in both directions.
- R7: Each button's state bit holds its level from the most recent update strobe.
- R8: Each button's duration field goes up by 1 on every prescaler tick. It goes back to 0 on a strobe carrying that button's own change flag, and that restart wins over a tick in the same cycle. The change flags of other lines do not affect it.
- R9: A duration field stops at 127.
- R10: The 8-bit idle field goes up by 1 on every tick and stops at 255. It goes back to 0 on any strobe with at least one change flag set.
- R11: Each encoder slice is 16 bits: button state in [15], duration in [14:8], pressed position in [7:4] and normal position in [3:0]. `r0` holds encoder 0 in [15:0] and encoder 1 in [31:16]. `r1` holds encoder 2 and encoder 3 in the same way. `r2` holds encoder 4 in [15:0], the idle field in [23:16], the standalone button's duration in [30:24] and its state in [31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btnLevel | input | 16 | Debounced levels of quadrature lines and buttons |
| chgFlags | input | 16 | Per-line change flags, valid with the strobe |
| updStrobe | input | 1 | One-cycle pulse qualifying levels and flags |
| r0 | output | 32 | Status of encoders 0 and 1 |
| r1 | output | 32 | Status of encoders 2 and 3 |
| r2 | output | 32 | Status of encoder 4, idle time and standalone button |

## Verification
The bench sets the prescaler period to 16 cycles. With that setting, the 127 limit on button durations and the 255 limit on the idle field are reached within a few thousand cycles, and each saturation is observed directly. Because the tick period is short, an exact number of ticks can be counted after a restart whatever the prescaler phase. The quadrature table drives encoder 0 through forward and reverse detents, skipped phases, partial cycles and a wrap below zero. Directed sequences then confirm where encoders 3 and 4 and the standalone button land in the output words.

// File: rtl/enc_status_pkg.sv
package enc_status_pkg;
  localparam int NUM_ENC = 5;
  localparam int NUM_BTN = NUM_ENC + 1;
  localparam int IN_W    = 3 * NUM_ENC + 1;
  localparam int POS_W   = 4;
  localparam int DUR_W   = 7;
  localparam int IDLE_W  = 8;
  localparam int SLICE_W = 1 + DUR_W + 2 * POS_W;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic                tick;
    logic [NUM_ENC-1:0]  stepUp;
    logic [NUM_ENC-1:0]  stepDn;
    logic [NUM_BTN-1:0]  durRestart;
    logic                idleRestart;
    logic                sample;
  } ctlStrobes_t;
endpackage

// File: rtl/enc_status_ctl.sv
module enc_status_ctl
  import enc_status_pkg::*;
#(
  parameter int TICK_CYCLES = 10_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ENC-1:0] quadA,
  input  logic [NUM_ENC-1:0] quadB,
  input  logic [IN_W-1:0]    chgFlags,
  input  logic               updStrobe,
  output ctlStrobes_t        strb
);
  localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [TICK_W-1:0]  preCnt;
  logic               preWrap;
  logic [NUM_ENC-1:0] upVec, dnVec;
  logic [NUM_BTN-1:0] restartVec;

  assign preWrap = (preCnt == TICK_W'(TICK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst)          preCnt <= '0;
    else if (preWrap) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  // per-encoder quadrature step tracker: phase runs -3..+3, 0 is detent
  for (genvar g = 0; g < NUM_ENC; g++) begin : g_quad
    logic [1:0] binPos;
    logic [1:0] diff;
    logic [2:0] phaseQ, phaseD;

    assign binPos = {quadA[g], quadA[g] ^ quadB[g]};

    always_comb begin
      diff   = binPos - phaseQ[1:0];
      phaseD = phaseQ;
      if (binPos == 2'd0)    phaseD = 3'd0;
      else if (diff == 2'd1) phaseD = phaseQ + 3'd1;
      else if (diff == 2'd3) phaseD = phaseQ - 3'd1;
    end

    always_ff @(posedge clk) begin
      if (rst)            phaseQ <= 3'd0;
      else if (updStrobe) phaseQ <= phaseD;
    end

    assign upVec[g]      = updStrobe && (binPos == 2'd0) && (phaseQ == 3'b011);
    assign dnVec[g]      = updStrobe && (binPos == 2'd0) && (phaseQ == 3'b101);
    assign restartVec[g] = updStrobe && chgFlags[3*g+2];
  end

  assign restartVec[NUM_ENC] = updStrobe && chgFlags[IN_W-1];

  assign strb.tick        = preWrap;
  assign strb.stepUp      = upVec;
  assign strb.stepDn      = dnVec;
  assign strb.durRestart  = restartVec;
  assign strb.idleRestart = updStrobe && (|chgFlags);
  assign strb.sample      = updStrobe;
endmodule

// File: rtl/enc_status_dp.sv
module enc_status_dp
  import enc_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobes_t        strb,
  input  logic [NUM_BTN-1:0] btnHeld,
  output logic [31:0]        r0,
  output logic [31:0]        r1,
  output logic [31:0]        r2
);
  localparam logic [DUR_W-1:0]  DUR_MAX  = {DUR_W{1'b1}};
  localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};

  logic [NUM_BTN-1:0]             btnState;
  logic [NUM_BTN-1:0][DUR_W-1:0]  durQ;
  logic [NUM_ENC-1:0][POS_W-1:0]  posNorm, posPress;
  logic [IDLE_W-1:0]              idleQ;
  logic [NUM_ENC-1:0][SLICE_W-1:0] slice;

  always_ff @(posedge clk) begin
    if (rst) begin
      btnState <= '0;
      durQ     <= '0;
      posNorm  <= '0;
      posPress <= '0;
      idleQ    <= '0;
    end else begin
      if (strb.sample) btnState <= btnHeld;

      for (int b = 0; b < NUM_BTN; b++) begin
        if (strb.durRestart[b])                   durQ[b] <= '0;
        else if (strb.tick && durQ[b] != DUR_MAX) durQ[b] <= durQ[b] + 1'b1;
      end

      for (int e = 0; e < NUM_ENC; e++) begin
        if (strb.stepUp[e]) begin
          if (btnHeld[e]) posPress[e] <= posPress[e] + 1'b1;
          else            posNorm[e]  <= posNorm[e] + 1'b1;
        end else if (strb.stepDn[e]) begin
          if (btnHeld[e]) posPress[e] <= posPress[e] - 1'b1;
          else            posNorm[e]  <= posNorm[e] - 1'b1;
        end
      end

      if (strb.idleRestart)                    idleQ <= '0;
      else if (strb.tick && idleQ != IDLE_MAX) idleQ <= idleQ + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_ENC; g++) begin : g_pack
    assign slice[g] = {btnState[g], durQ[g], posPress[g], posNorm[g]};
  end

  assign r0 = {slice[1], slice[0]};
  assign r1 = {slice[3], slice[2]};
  assign r2 = {btnState[NUM_ENC], durQ[NUM_ENC], idleQ, slice[4]};
endmodule

// File: rtl/enc_status_regs.sv
module enc_status_regs
  import enc_status_pkg::*;
#(
  parameter int TICK_CYCLES = 10_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] btnLevel,
  input  logic [15:0] chgFlags,
  input  logic        updStrobe,
  output logic [31:0] r0,
  output logic [31:0] r1,
  output logic [31:0] r2
);
  logic [NUM_ENC-1:0] quadA, quadB;
  logic [NUM_BTN-1:0] btnHeld;
  ctlStrobes_t        strb;

  for (genvar g = 0; g < NUM_ENC; g++) begin : g_split
    assign quadA[g]   = btnLevel[3*g];
    assign quadB[g]   = btnLevel[3*g+1];
    assign btnHeld[g] = btnLevel[3*g+2];
  end
  assign btnHeld[NUM_ENC] = btnLevel[IN_W-1];

  enc_status_ctl #(.TICK_CYCLES(TICK_CYCLES)) u_ctl (
    .clk(clk), .rst(rst), .quadA(quadA), .quadB(quadB),
    .chgFlags(chgFlags), .updStrobe(updStrobe), .strb(strb)
  );

  enc_status_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .btnHeld(btnHeld),
    .r0(r0), .r1(r1), .r2(r2)
  );
endmodule

// File: rtl/enc_status_chk.sv
module enc_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        updStrobe,
  input logic [15:0] chgFlags,
  input logic        encBtn0,
  input logic        soloBtn,
  input logic [7:0]  r0Pos,
  input logic        r0Btn,
  input logic [6:0]  r0Dur,
  input logic [15:0] r1Pos,
  input logic [7:0]  r2Pos,
  input logic [7:0]  r2Idle,
  input logic        r2Btn
);
  // R2: with no strobe, positions and button states hold
  p_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !updStrobe |=> ($stable(r0Pos) && $stable(r1Pos) && $stable(r2Pos) &&
                    $stable(r0Btn) && $stable(r2Btn)));

  // R3 / R6: a normal counter moves by exactly one step, wrapping
  p_pos_step_r3: assert property (@(posedge clk) disable iff (rst)
    (r0Pos[3:0] != $past(r0Pos[3:0])) |->
      ((4'(r0Pos[3:0] - $past(r0Pos[3:0])) == 4'd1) ||
       (4'(r0Pos[3:0] - $past(r0Pos[3:0])) == 4'hF)));

  // R7: state bit follows the level sampled at the strobe
  p_state_r7: assert property (@(posedge clk) disable iff (rst)
    updStrobe |=> (r0Btn == $past(encBtn0) && r2Btn == $past(soloBtn)));

  // R8: own change flag restarts the duration
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (updStrobe && chgFlags[2]) |=> (r0Dur == 7'd0));

  // R9: a saturated duration stays put until restarted
  p_dur_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (r0Dur == 7'd127 && !(updStrobe && chgFlags[2])) |=> (r0Dur == 7'd127));

  // R10: idle field restart and saturation
  p_idle_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (updStrobe && (|chgFlags)) |=> (r2Idle == 8'd0));
  p_idle_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (r2Idle == 8'd255 && !(updStrobe && (|chgFlags))) |=> (r2Idle == 8'd255));
endmodule

bind enc_status_regs enc_status_chk u_chk (
  .clk(clk), .rst(rst), .updStrobe(updStrobe), .chgFlags(chgFlags),
  .encBtn0(btnLevel[2]), .soloBtn(btnLevel[15]),
  .r0Pos(r0[7:0]), .r0Btn(r0[15]), .r0Dur(r0[14:8]),
  .r1Pos({r1[23:16], r1[7:0]}), .r2Pos(r2[7:0]),
  .r2Idle(r2[23:16]), .r2Btn(r2[31])
);

// File: tb/enc_status_regs_test.sv
module enc_status_regs_test;
  localparam int TICK = 16;
  localparam int NVEC = 28;
  // {A, B, button of encoder 0} then expected {pressed, normal} nibbles
  localparam logic [10:0] VEC [NVEC] = '{
    {3'b010, 8'h00}, {3'b110, 8'h00}, {3'b100, 8'h00}, {3'b000, 8'h01},
    {3'b010, 8'h01}, {3'b110, 8'h01}, {3'b100, 8'h01}, {3'b000, 8'h02},
    {3'b100, 8'h02}, {3'b110, 8'h02}, {3'b010, 8'h02}, {3'b000, 8'h01},
    {3'b011, 8'h01}, {3'b111, 8'h01}, {3'b101, 8'h01}, {3'b001, 8'h11},
    {3'b110, 8'h11}, {3'b000, 8'h11}, {3'b010, 8'h11}, {3'b000, 8'h11},
    {3'b101, 8'h11}, {3'b111, 8'h11}, {3'b011, 8'h11}, {3'b001, 8'h01},
    {3'b101, 8'h01}, {3'b111, 8'h01}, {3'b011, 8'h01}, {3'b001, 8'hF1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] btnLevel = '0;
  logic [15:0] chgFlags = '0;
  logic        updStrobe = 1'b0;
  logic [31:0] r0, r1, r2;
  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  enc_status_regs #(.TICK_CYCLES(TICK)) uut (
    .clk(clk), .rst(rst), .btnLevel(btnLevel), .chgFlags(chgFlags),
    .updStrobe(updStrobe), .r0(r0), .r1(r1), .r2(r2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply levels and flags for one strobed cycle; outputs valid on return
  task automatic pulse(input logic [15:0] lv, input logic [15:0] cf);
    @(negedge clk);
    btnLevel  = lv;
    chgFlags  = cf;
    updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
    chgFlags  = '0;
  endtask

  task automatic detent(input int enc, input bit held);
    logic [1:0] seq [4] = '{2'b01, 2'b11, 2'b10, 2'b00};
    for (int i = 0; i < 4; i++) begin
      logic [15:0] lv = btnLevel;
      lv[3*enc]   = seq[i][1];
      lv[3*enc+1] = seq[i][0];
      lv[3*enc+2] = held;
      pulse(lv, '0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 r0 after reset", r0, 32'h0);
    check("R1 r1 after reset", r1, 32'h0);
    check("R1 r2 after reset", r2, 32'h0);

    repeat (TICK * 260) @(negedge clk);
    check("R10 idle saturates at 255", {24'h0, r2[23:16]}, 32'd255);
    check("R9 encoder0 duration saturates", {25'h0, r0[14:8]}, 32'd127);
    check("R9 standalone duration saturates", {25'h0, r2[30:24]}, 32'd127);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] lv = '0;
      lv[0] = VEC[i][10];
      lv[1] = VEC[i][9];
      lv[2] = VEC[i][8];
      pulse(lv, '0);
      check($sformatf("R3 R4 R5 R6 table row %0d", i), {24'h0, r0[7:0]}, {24'h0, VEC[i][7:0]});
    end
    check("R7 encoder0 button state held", {31'h0, r0[15]}, 32'd1);

    pulse(16'h0004, 16'h0004);
    repeat (TICK * 5) @(negedge clk);
    check("R8 encoder0 duration after 5 ticks", {25'h0, r0[14:8]}, 32'd5);
    check("R8 encoder1 duration unaffected", {25'h0, r0[30:24]}, 32'd127);
    check("R10 idle restarted by change", {24'h0, r2[23:16]}, 32'd5);

    // R2: activity without strobe is ignored
    @(negedge clk);
    btnLevel = 16'h0001; chgFlags = 16'h0004;
    @(negedge clk);
    btnLevel = 16'h0003;
    @(negedge clk);
    btnLevel = 16'h0002;
    @(negedge clk);
    btnLevel = 16'h0000; chgFlags = 16'h0000;
    repeat (TICK - 3) @(negedge clk);
    check("R2 no restart without strobe", {25'h0, r0[14:8]}, 32'd6);
    check("R2 no count without strobe", {24'h0, r0[7:0]}, 32'h000000F1);
    check("R2 state held without strobe", {31'h0, r0[15]}, 32'd1);

    pulse(16'h8000, '0);
    check("R7 encoder0 state released", {31'h0, r0[15]}, 32'd0);
    check("R7 R11 standalone state in r2[31]", {31'h0, r2[31]}, 32'd1);

    pulse(16'h0000, '0);
    detent(4, 1'b0);
    check("R11 encoder4 normal in r2[3:0]", {24'h0, r2[7:0]}, 32'h00000001);
    detent(3, 1'b1);
    check("R5 R11 encoder3 pressed in r1[23:20]", {16'h0, r1[31:16]}, {16'h0, 1'b1, r1[30:24], 8'h10});
    check("R11 encoder2 untouched", {24'h0, r1[7:0]}, 32'h0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    btnLevel = '0;
    @(negedge clk);
    check("R1 r0 after second reset", r0, 32'h0);
    check("R1 r2 after second reset", r2, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule